// File: doc/BRIEF.md
# Cross-Node Address Mapper for Twin-Host Link

This block sits between a node's system bus and a point-to-point link that joins two peer nodes with identical address maps. On the way out it looks at each system-bus request. Requests whose address lies in a reserved 64 GB window (top address nibble `E`) go to the link, and every other request goes to a local pass port. Link-bound requests always leave with the L2-cacheable attribute cleared, because such traffic crosses the coherency boundary.

On the way in, the node claims link requests that carry the same window. It clears the top nibble, which folds the address onto the low 64 GB. A second decode then picks a destination. Three programmable inclusive base/limit windows, at 1 MB granularity, choose the local system bus, the local PCI segment, or re-emission onto the link, checked in that priority order. A request that is not claimed, or that misses all three windows, is sent to a master-abort response port. Every request is routed in the cycle it is presented, through a valid/ready pair on each side.

The window registers answer configuration accesses only at device 0, function 0. A role input is captured once as the reset is released. The captured value tells the surrounding logic whether this node is the one that enumerates the chain.

Top module: `xnode_map`

## Requirements
- R1: An outbound request whose address bits [39:36] equal 4'hE appears on the link port with its address unchanged. Any other outbound request appears on the pass port. Only one of these two ports is valid at a time.
- R2: A link-bound outbound request always carries L2-cacheable = 0. A request on the pass port carries `ob_l2ca_i` unchanged.
- R3: `ob_ready_o` equals the ready input of whichever outbound port the current request selects, in the same cycle.
- R4: An inbound request with bits [39:36] = 4'hE is claimed. Every inbound target address equals the request address with bits [39:36] cleared and bits [35:0] kept.
- R5: The second decode takes field F = remapped address bits [35:20]. Window w hits when base_w <= F <= limit_w, with both bounds inclusive. On overlap the system-bus window (w=0) wins over PCI (w=1), and PCI wins over link re-emission (w=2).
- R6: The abort port is selected by an inbound request that is not claimed, or by a claimed request that hits no window.
- R7: While `ib_valid_i` is high, exactly one of sb/pci/rt/ab valid is high, and `ib_ready_o` equals that port's ready. While `ib_valid_i` is low, none of them is high.
- R8: A configuration write takes effect only when device = 0 and function = 0. Reads at device 0, function 0 return the register in bits [15:0] with zeros above it. Reads at any other device or function return 32'hFFFF_FFFF. A write is visible to a read and to routing from the next cycle on.
- R9: The register index gives the window as index/2 and selects base on even indexes and limit on odd ones. Indexes 0/1 belong to the system bus, 2/3 to PCI and 4/5 to link re-emission. After reset every base is 16'hFFFF and every limit is 0, so no window hits.
- R10: `chain_master_o` takes the value of `role_i` at the first clock edge after the internal reset releases. It then holds that value until the next reset, whatever `role_i` does.
- R11: `rst_n` asserts asynchronously. While it is low, `chain_master_o` is 0 and the window registers hold their reset values. Its release is resynchronised through two flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_i | input | 1 | Node role, 1 = chain master |
| chain_master_o | output | 1 | Captured role |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_dev_i | input | 5 | Configuration device number |
| cfg_fn_i | input | 3 | Configuration function number |
| cfg_idx_i | input | 3 | Window register index |
| cfg_wdata_i | input | 16 | Write data, address bits [35:20] |
| cfg_rdata_o | output | 32 | Read data |
| ob_valid_i | input | 1 | Outbound request valid |
| ob_ready_o | output | 1 | Outbound request ready |
| ob_addr_i | input | 40 | Outbound address |
| ob_l2ca_i | input | 1 | Outbound L2-cacheable attribute |
| ol_valid_o | output | 1 | To-link valid |
| ol_ready_i | input | 1 | To-link ready |
| ol_addr_o | output | 40 | To-link address |
| ol_l2ca_o | output | 1 | To-link L2-cacheable attribute |
| op_valid_o | output | 1 | Pass-port valid |
| op_ready_i | input | 1 | Pass-port ready |
| op_addr_o | output | 40 | Pass-port address |
| op_l2ca_o | output | 1 | Pass-port L2-cacheable attribute |
| ib_valid_i | input | 1 | Inbound request valid |
| ib_ready_o | output | 1 | Inbound request ready |
| ib_addr_i | input | 40 | Inbound address |
| sb_valid_o | output | 1 | System-bus target valid |
| sb_ready_i | input | 1 | System-bus target ready |
| sb_addr_o | output | 40 | System-bus target address |
| pci_valid_o | output | 1 | PCI target valid |
| pci_ready_i | input | 1 | PCI target ready |
| pci_addr_o | output | 40 | PCI target address |
| rt_valid_o | output | 1 | Re-emission valid |
| rt_ready_i | input | 1 | Re-emission ready |
| rt_addr_o | output | 40 | Re-emission address |
| ab_valid_o | output | 1 | Master-abort response valid |
| ab_ready_i | input | 1 | Master-abort response ready |

## Verification
Routing and ready are combinational, so every outbound and inbound result is due in the same cycle as its stimulus. The bench changes inputs just after a rising edge and reads the outputs at the following falling edge. A configuration write is registered, so the bench lets one rising edge pass before it reads the value back or sends traffic that relies on the new window. The captured role appears only after the two-flop reset synchroniser and one capture edge. The bench therefore waits several cycles after the reset release before it reads `chain_master_o`, and reads it again after `role_i` has changed.

// File: rtl/xnode_pkg.sv
package xnode_pkg;
  localparam int unsigned XN_AW      = 40;
  localparam int unsigned XN_NIB_W   = 4;
  localparam int unsigned XN_WIN_LSB = 20;
  localparam int unsigned XN_NWIN    = 3;
  localparam logic [3:0]  XN_WIN_NIB = 4'hE;

  typedef enum logic [1:0] {
    TGT_SB  = 2'd0,
    TGT_PCI = 2'd1,
    TGT_RT  = 2'd2,
    TGT_AB  = 2'd3
  } tgt_e;
endpackage

// File: rtl/xnode_rst_sync.sv
module xnode_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/xnode_cfg_regs.sv
module xnode_cfg_regs #(
  parameter int unsigned NWIN = 3,
  parameter int unsigned FW   = 16,
  parameter int unsigned IW   = 3
) (
  input  logic                          clk,
  input  logic                          srst_n,
  input  logic                          cfg_wr_i,
  input  logic [4:0]                    cfg_dev_i,
  input  logic [2:0]                    cfg_fn_i,
  input  logic [IW-1:0]                 cfg_idx_i,
  input  logic [FW-1:0]                 cfg_wdata_i,
  output logic [31:0]                   cfg_rdata_o,
  output logic [NWIN-1:0][1:0][FW-1:0]  win_o
);
  localparam int unsigned NREG = 2 * NWIN;

  logic [NWIN-1:0][1:0][FW-1:0] win_q, win_d;
  logic                          hit_fn;
  logic                          idx_ok;
  logic                          wr_en;
  logic [IW-2:0]                 w_sel;

  assign hit_fn = (cfg_dev_i == 5'd0) && (cfg_fn_i == 3'd0);
  assign idx_ok = (32'(cfg_idx_i) < NREG);
  assign wr_en  = cfg_wr_i && hit_fn && idx_ok;
  assign w_sel  = cfg_idx_i[IW-1:1];

  always_comb begin
    win_d = win_q;
    if (wr_en) win_d[w_sel][cfg_idx_i[0]] = cfg_wdata_i;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      for (int w = 0; w < int'(NWIN); w++) begin
        win_q[w][0] <= '1;
        win_q[w][1] <= '0;
      end
    end else if (wr_en) begin
      win_q <= win_d;
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (!hit_fn)     cfg_rdata_o = '1;
    else if (idx_ok) cfg_rdata_o = 32'(win_q[w_sel][cfg_idx_i[0]]);
  end

  assign win_o = win_q;

  p_foreign_ignored_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (cfg_wr_i && !hit_fn) |=> $stable(win_q))
    else $error("config write at foreign device/function changed state");
endmodule

// File: rtl/xnode_ob_class.sv
module xnode_ob_class #(
  parameter int unsigned AW    = 40,
  parameter int unsigned NIB_W = 4,
  parameter logic [NIB_W-1:0] WIN_NIB = 4'hE
) (
  input  logic          ob_valid_i,
  output logic          ob_ready_o,
  input  logic [AW-1:0] ob_addr_i,
  input  logic          ob_l2ca_i,
  output logic          ol_valid_o,
  input  logic          ol_ready_i,
  output logic [AW-1:0] ol_addr_o,
  output logic          ol_l2ca_o,
  output logic          op_valid_o,
  input  logic          op_ready_i,
  output logic [AW-1:0] op_addr_o,
  output logic          op_l2ca_o
);
  logic to_link;

  assign to_link    = (ob_addr_i[AW-1 -: NIB_W] == WIN_NIB);
  assign ol_valid_o = ob_valid_i && to_link;
  assign op_valid_o = ob_valid_i && !to_link;
  assign ol_addr_o  = ob_addr_i;
  assign op_addr_o  = ob_addr_i;
  assign ol_l2ca_o  = 1'b0;
  assign op_l2ca_o  = ob_l2ca_i;
  assign ob_ready_o = to_link ? ol_ready_i : op_ready_i;
endmodule

// File: rtl/xnode_ib_decode.sv
module xnode_ib_decode
  import xnode_pkg::*;
#(
  parameter int unsigned AW      = 40,
  parameter int unsigned NIB_W   = 4,
  parameter int unsigned WIN_LSB = 20,
  parameter int unsigned NWIN    = 3,
  parameter logic [NIB_W-1:0] WIN_NIB = 4'hE,
  localparam int unsigned FW     = AW - NIB_W - WIN_LSB
) (
  input  logic [AW-1:0]                 ib_addr_i,
  input  logic [NWIN-1:0][1:0][FW-1:0]  win_i,
  output logic [AW-1:0]                 remap_o,
  output logic                          claim_o,
  output tgt_e                          tgt_o
);
  logic [FW-1:0]   field;
  logic [NWIN-1:0] hit;

  assign claim_o = (ib_addr_i[AW-1 -: NIB_W] == WIN_NIB);
  assign remap_o = {{NIB_W{1'b0}}, ib_addr_i[AW-NIB_W-1:0]};
  assign field   = remap_o[AW-NIB_W-1 : WIN_LSB];

  for (genvar w = 0; w < int'(NWIN); w++) begin : g_win
    assign hit[w] = (field >= win_i[w][0]) && (field <= win_i[w][1]);
  end

  always_comb begin
    tgt_o = TGT_AB;
    if (claim_o) begin
      for (int w = int'(NWIN) - 1; w >= 0; w--) begin
        if (hit[w]) tgt_o = tgt_e'(w);
      end
    end
  end
endmodule

// File: rtl/xnode_map.sv
module xnode_map
  import xnode_pkg::*;
#(
  parameter int unsigned AW      = XN_AW,
  parameter int unsigned WIN_LSB = XN_WIN_LSB,
  localparam int unsigned NIB_W  = XN_NIB_W,
  localparam int unsigned NWIN   = XN_NWIN,
  localparam int unsigned FW     = AW - NIB_W - WIN_LSB,
  localparam int unsigned IW     = $clog2(2 * NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          role_i,
  output logic          chain_master_o,
  input  logic          cfg_wr_i,
  input  logic [4:0]    cfg_dev_i,
  input  logic [2:0]    cfg_fn_i,
  input  logic [IW-1:0] cfg_idx_i,
  input  logic [FW-1:0] cfg_wdata_i,
  output logic [31:0]   cfg_rdata_o,
  input  logic          ob_valid_i,
  output logic          ob_ready_o,
  input  logic [AW-1:0] ob_addr_i,
  input  logic          ob_l2ca_i,
  output logic          ol_valid_o,
  input  logic          ol_ready_i,
  output logic [AW-1:0] ol_addr_o,
  output logic          ol_l2ca_o,
  output logic          op_valid_o,
  input  logic          op_ready_i,
  output logic [AW-1:0] op_addr_o,
  output logic          op_l2ca_o,
  input  logic          ib_valid_i,
  output logic          ib_ready_o,
  input  logic [AW-1:0] ib_addr_i,
  output logic          sb_valid_o,
  input  logic          sb_ready_i,
  output logic [AW-1:0] sb_addr_o,
  output logic          pci_valid_o,
  input  logic          pci_ready_i,
  output logic [AW-1:0] pci_addr_o,
  output logic          rt_valid_o,
  input  logic          rt_ready_i,
  output logic [AW-1:0] rt_addr_o,
  output logic          ab_valid_o,
  input  logic          ab_ready_i
);
  logic                          srst_n;
  logic [NWIN-1:0][1:0][FW-1:0]  win;
  logic [AW-1:0]                 remap;
  logic                          claim;
  tgt_e                          tgt;
  logic                          role_q, role_d;
  logic                          cap_q, cap_d;

  xnode_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  // role capture: first edge after internal release, then frozen
  always_comb begin
    role_d = role_q;
    cap_d  = cap_q;
    if (!cap_q) begin
      role_d = role_i;
      cap_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      role_q <= 1'b0;
      cap_q  <= 1'b0;
    end else if (!cap_q) begin
      role_q <= role_d;
      cap_q  <= cap_d;
    end
  end

  assign chain_master_o = role_q;

  xnode_cfg_regs #(.NWIN(NWIN), .FW(FW), .IW(IW)) i_cfg (
    .clk         (clk),
    .srst_n      (srst_n),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_dev_i   (cfg_dev_i),
    .cfg_fn_i    (cfg_fn_i),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .win_o       (win)
  );

  xnode_ob_class #(.AW(AW), .NIB_W(NIB_W), .WIN_NIB(XN_WIN_NIB)) i_ob (
    .ob_valid_i (ob_valid_i),
    .ob_ready_o (ob_ready_o),
    .ob_addr_i  (ob_addr_i),
    .ob_l2ca_i  (ob_l2ca_i),
    .ol_valid_o (ol_valid_o),
    .ol_ready_i (ol_ready_i),
    .ol_addr_o  (ol_addr_o),
    .ol_l2ca_o  (ol_l2ca_o),
    .op_valid_o (op_valid_o),
    .op_ready_i (op_ready_i),
    .op_addr_o  (op_addr_o),
    .op_l2ca_o  (op_l2ca_o)
  );

  xnode_ib_decode #(.AW(AW), .NIB_W(NIB_W), .WIN_LSB(WIN_LSB), .NWIN(NWIN),
                    .WIN_NIB(XN_WIN_NIB)) i_ib (
    .ib_addr_i (ib_addr_i),
    .win_i     (win),
    .remap_o   (remap),
    .claim_o   (claim),
    .tgt_o     (tgt)
  );

  assign sb_valid_o  = ib_valid_i && (tgt == TGT_SB);
  assign pci_valid_o = ib_valid_i && (tgt == TGT_PCI);
  assign rt_valid_o  = ib_valid_i && (tgt == TGT_RT);
  assign ab_valid_o  = ib_valid_i && (tgt == TGT_AB);
  assign sb_addr_o   = remap;
  assign pci_addr_o  = remap;
  assign rt_addr_o   = remap;

  always_comb begin
    unique case (tgt)
      TGT_SB:  ib_ready_o = sb_ready_i;
      TGT_PCI: ib_ready_o = pci_ready_i;
      TGT_RT:  ib_ready_o = rt_ready_i;
      default: ib_ready_o = ab_ready_i;
    endcase
  end

  p_link_same_addr_r1: assert property (@(posedge clk) disable iff (!srst_n)
    ol_valid_o |-> (ol_addr_o == ob_addr_i) && !op_valid_o)
    else $error("link-bound request altered or duplicated");

  p_link_nocache_r2: assert property (@(posedge clk) disable iff (!srst_n)
    ol_valid_o |-> !ol_l2ca_o)
    else $error("link-bound request marked cacheable");

  p_low_map_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (sb_valid_o || pci_valid_o || rt_valid_o) |->
      (sb_addr_o[AW-1 -: NIB_W] == '0) && (sb_addr_o[AW-NIB_W-1:0] == ib_addr_i[AW-NIB_W-1:0]))
    else $error("inbound target address not folded to low space");

  p_unclaimed_abort_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (ib_valid_i && (ib_addr_i[AW-1 -: NIB_W] != XN_WIN_NIB)) |-> ab_valid_o)
    else $error("unclaimed inbound request not aborted");

  p_one_target_r7: assert property (@(posedge clk) disable iff (!srst_n)
    $countones({sb_valid_o, pci_valid_o, rt_valid_o, ab_valid_o}) == (ib_valid_i ? 1 : 0))
    else $error("inbound target valids not exactly one");

  p_role_hold_r10: assert property (@(posedge clk) disable iff (!srst_n)
    cap_q |=> $stable(chain_master_o))
    else $error("captured role changed");
endmodule

// File: tb/test_xnode_map.sv
module test_xnode_map;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        role_i;
  logic        chain_master_o;
  logic        cfg_wr_i;
  logic [4:0]  cfg_dev_i;
  logic [2:0]  cfg_fn_i;
  logic [2:0]  cfg_idx_i;
  logic [15:0] cfg_wdata_i;
  logic [31:0] cfg_rdata_o;
  logic        ob_valid_i, ob_ready_o, ob_l2ca_i;
  logic [39:0] ob_addr_i;
  logic        ol_valid_o, ol_ready_i, ol_l2ca_o;
  logic [39:0] ol_addr_o;
  logic        op_valid_o, op_ready_i, op_l2ca_o;
  logic [39:0] op_addr_o;
  logic        ib_valid_i, ib_ready_o;
  logic [39:0] ib_addr_i;
  logic        sb_valid_o, sb_ready_i;
  logic [39:0] sb_addr_o;
  logic        pci_valid_o, pci_ready_i;
  logic [39:0] pci_addr_o;
  logic        rt_valid_o, rt_ready_i;
  logic [39:0] rt_addr_o;
  logic        ab_valid_o, ab_ready_i;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  xnode_map i_xnode_map (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic cfg_write(input logic [4:0] dev, input logic [2:0] fn,
                           input logic [2:0] idx, input logic [15:0] val);
    step();
    cfg_wr_i = 1'b1; cfg_dev_i = dev; cfg_fn_i = fn; cfg_idx_i = idx; cfg_wdata_i = val;
    step();
    cfg_wr_i = 1'b0; cfg_dev_i = 5'd0; cfg_fn_i = 3'd0;
  endtask

  task automatic cfg_read(input logic [4:0] dev, input logic [2:0] fn,
                          input logic [2:0] idx, output logic [31:0] val);
    step();
    cfg_dev_i = dev; cfg_fn_i = fn; cfg_idx_i = idx;
    @(negedge clk);
    val = cfg_rdata_o;
    cfg_dev_i = 5'd0; cfg_fn_i = 3'd0;
  endtask

  // drives an inbound request, returns {ab,rt,pci,sb} valids
  task automatic ib_send(input logic [39:0] a, output logic [3:0] v);
    step();
    ib_valid_i = 1'b1; ib_addr_i = a;
    @(negedge clk);
    v = {ab_valid_o, rt_valid_o, pci_valid_o, sb_valid_o};
  endtask

  task automatic do_reset(input logic role);
    rst_n = 1'b0; role_i = role;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 master low in reset", 64'(chain_master_o), 64'd0);
    cfg_dev_i = 5'd0; cfg_fn_i = 3'd0; cfg_idx_i = 3'd0;
    @(negedge clk);
    chk("R11 base reset value", 64'(cfg_rdata_o), 64'h0000_FFFF);
    cfg_idx_i = 3'd5;
    @(negedge clk);
    chk("R9 limit reset value", 64'(cfg_rdata_o), 64'h0);
    do_reset(1'b0);
    cfg_read(5'd0, 3'd0, 3'd2, r);
    chk("R9 pci base after reset", 64'(r), 64'h0000_FFFF);
  endtask

  task automatic t_empty_windows();
    logic [3:0] v;
    ib_send(40'hE0_0000_0000, v);
    chk("R9 no hit after reset -> abort", 64'(v), 64'b1000);
    ib_valid_i = 1'b0;
  endtask

  task automatic t_outbound();
    step();
    ob_valid_i = 1'b1; ob_addr_i = 40'hE3_0000_1000; ob_l2ca_i = 1'b1;
    ol_ready_i = 1'b0; op_ready_i = 1'b1;
    @(negedge clk);
    chk("R1 window to link", 64'({ol_valid_o, op_valid_o}), 64'b10);
    chk("R1 link addr", 64'(ol_addr_o), 64'hE3_0000_1000);
    chk("R2 link l2ca cleared", 64'(ol_l2ca_o), 64'd0);
    chk("R3 ready follows link ready=0", 64'(ob_ready_o), 64'd0);
    step(); ol_ready_i = 1'b1; op_ready_i = 1'b0;
    @(negedge clk);
    chk("R3 ready follows link ready=1", 64'(ob_ready_o), 64'd1);
    step(); ob_addr_i = 40'h00_1000_0040;
    @(negedge clk);
    chk("R1 low addr to pass", 64'({ol_valid_o, op_valid_o}), 64'b01);
    chk("R2 pass keeps l2ca", 64'(op_l2ca_o), 64'd1);
    chk("R1 pass addr", 64'(op_addr_o), 64'h00_1000_0040);
    chk("R3 ready follows pass ready=0", 64'(ob_ready_o), 64'd0);
    step(); ob_addr_i = 40'hF0_0000_0000; ob_l2ca_i = 1'b0;
    @(negedge clk);
    chk("R1 nibble F to pass", 64'({ol_valid_o, op_valid_o}), 64'b01);
    chk("R2 pass keeps l2ca=0", 64'(op_l2ca_o), 64'd0);
    step(); ob_valid_i = 1'b0;
    @(negedge clk);
    chk("R1 no valid when idle", 64'({ol_valid_o, op_valid_o}), 64'b00);
  endtask

  task automatic t_inbound_targets();
    logic [3:0] v;
    cfg_write(5'd0, 3'd0, 3'd0, 16'h0000);
    cfg_write(5'd0, 3'd0, 3'd1, 16'h00FF);
    cfg_write(5'd0, 3'd0, 3'd2, 16'h0100);
    cfg_write(5'd0, 3'd0, 3'd3, 16'h01FF);
    cfg_write(5'd0, 3'd0, 3'd4, 16'h0200);
    cfg_write(5'd0, 3'd0, 3'd5, 16'h02FF);
    ib_send(40'hE0_0123_4567, v);
    chk("R5 sb window hit", 64'(v), 64'b0001);
    chk("R4 remapped addr", 64'(sb_addr_o), 64'h00_0123_4567);
    sb_ready_i = 1'b0;
    #1 chk("R7 ready follows sb ready", 64'(ib_ready_o), 64'd0);
    sb_ready_i = 1'b1;
    ib_send(40'hE0_0FFF_FFFF, v);
    chk("R5 sb limit inclusive", 64'(v), 64'b0001);
    ib_send(40'hE0_1000_0000, v);
    chk("R5 pci base inclusive", 64'(v), 64'b0010);
    ib_send(40'hE0_1234_5678, v);
    chk("R5 pci window hit", 64'(v), 64'b0010);
    chk("R4 pci addr", 64'(pci_addr_o), 64'h00_1234_5678);
    ib_send(40'hE0_2000_0000, v);
    chk("R5 link window hit", 64'(v), 64'b0100);
    chk("R4 rt addr", 64'(rt_addr_o), 64'h00_2000_0000);
    ab_ready_i = 1'b0;
    ib_send(40'hE0_8000_0000, v);
    chk("R6 claimed miss -> abort", 64'(v), 64'b1000);
    chk("R7 ready follows abort ready", 64'(ib_ready_o), 64'd0);
    ab_ready_i = 1'b1;
    ib_send(40'hD0_0123_4567, v);
    chk("R6 unclaimed -> abort", 64'(v), 64'b1000);
    step(); ib_valid_i = 1'b0;
    @(negedge clk);
    chk("R7 no valid when idle", 64'({ab_valid_o, rt_valid_o, pci_valid_o, sb_valid_o}), 64'b0);
  endtask

  task automatic t_priority();
    logic [3:0] v;
    cfg_write(5'd0, 3'd0, 3'd2, 16'h0000);
    cfg_write(5'd0, 3'd0, 3'd4, 16'h0000);
    cfg_write(5'd0, 3'd0, 3'd5, 16'hFFFF);
    ib_send(40'hE0_0500_0000, v);
    chk("R5 sb wins overlap", 64'(v), 64'b0001);
    cfg_write(5'd0, 3'd0, 3'd0, 16'hFFFF);
    cfg_write(5'd0, 3'd0, 3'd1, 16'h0000);
    ib_send(40'hE0_0500_0000, v);
    chk("R5 pci wins over link", 64'(v), 64'b0010);
    ib_send(40'hEF_FFFF_FFFF, v);
    chk("R5 link catches top", 64'(v), 64'b0100);
    chk("R4 top remap", 64'(rt_addr_o), 64'h0F_FFFF_FFFF);
    ib_valid_i = 1'b0;
  endtask

  task automatic t_cfg_foreign();
    logic [31:0] r;
    cfg_write(5'd0, 3'd0, 3'd3, 16'h0ABC);
    cfg_read(5'd0, 3'd0, 3'd3, r);
    chk("R8 write at dev0 fn0 visible", 64'(r), 64'h0000_0ABC);
    cfg_write(5'd1, 3'd0, 3'd3, 16'h1234);
    cfg_write(5'd0, 3'd2, 3'd3, 16'h5678);
    cfg_read(5'd0, 3'd0, 3'd3, r);
    chk("R8 foreign writes ignored", 64'(r), 64'h0000_0ABC);
    cfg_read(5'd3, 3'd0, 3'd3, r);
    chk("R8 foreign read all ones", 64'(r), 64'hFFFF_FFFF);
  endtask

  task automatic t_role();
    do_reset(1'b1);
    chk("R10 role captured", 64'(chain_master_o), 64'd1);
    role_i = 1'b0;
    repeat (4) step();
    @(negedge clk);
    chk("R10 role held after change", 64'(chain_master_o), 64'd1);
    do_reset(1'b0);
    chk("R10 role recaptured low", 64'(chain_master_o), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; role_i = 1'b0;
    cfg_wr_i = 1'b0; cfg_dev_i = '0; cfg_fn_i = '0; cfg_idx_i = '0; cfg_wdata_i = '0;
    ob_valid_i = 1'b0; ob_addr_i = '0; ob_l2ca_i = 1'b0;
    ol_ready_i = 1'b1; op_ready_i = 1'b1;
    ib_valid_i = 1'b0; ib_addr_i = '0;
    sb_ready_i = 1'b1; pci_ready_i = 1'b1; rt_ready_i = 1'b1; ab_ready_i = 1'b1;
    t_reset();
    t_empty_windows();
    t_outbound();
    t_inbound_targets();
    t_priority();
    t_cfg_foreign();
    t_role();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule